// File: doc/BRIEF.md
# Programmable Chip-Select Channel With Wait-State Termination

This block is one chip-select channel for a 32-bit bus master with a 24-bit address bus. At every bus cycle start it decides whether the cycle belongs to it. An ordinary access belongs to it when the upper address bits fall inside a programmed block and the cycle's address space is one the channel accepts. When the channel is programmed for CPU space, it instead serves interrupt acknowledge cycles: it claims such a cycle only when the priority level carried on ADDR[3:1] equals a programmed level.

Once a cycle is claimed, the channel drives an active-low select strobe. It ends the access with a one-clock termination acknowledge after a programmed number of wait states. A fast-termination code shortens the access to two clocks. An external code leaves the end of the cycle to an acknowledge from the addressed device.

A channel that serves ordinary spaces can also answer interrupt acknowledge cycles of a matching level with an autovector request instead of a strobe. Software programs two registers, a base register and an option register, through a simple write port.

Top module: `cs_channel`

## Requirements
- R1: After reset cs_n_o is high, term_ack_o and avec_o are low, and with both registers still all zero no cycle of any space or address asserts the strobe.
- R2: A write with cfg_sel_i=0 loads the base register: block base from cfg_wdata_i[23:11] and block size code from cfg_wdata_i[2:0]. A write with cfg_sel_i=1 loads the option register: termination code [3:0], autovector enable [4], priority level [7:5], space select [9:8].
- R3: In an ordinary space mode the block covers 2^(11+size) bytes. Only address bits at and above position 11+size are compared with the base.
- R4: cyc_space_i encodes the cycle's space as 0 CPU, 1 user, 2 supervisor, 3 reserved. Space select 1 accepts user cycles only, 2 supervisor only and 3 either. The reserved code is never accepted, and CPU cycles never assert the strobe in these modes.
- R5: With space select 0, a CPU-space cycle asserts the strobe only when ADDR[3:1] equals a nonzero programmed level. The base register plays no part, and the autovector bit has no effect: the ordinary termination acknowledge is used.
- R6: Termination codes 0 to 13 give an access of code+3 clocks, counting the clock in which cyc_start_i is sampled. cs_n_o is low for the code+2 clocks that follow that edge, and term_ack_o is high only in the last of them.
- R7: Termination code 14 gives a two-clock access: the strobe is low for one clock, with term_ack_o high in that same clock.
- R8: With termination code 15, term_ack_o never asserts. The strobe stays low until the clock edge at which ext_ack_i is sampled high, and returns high after that edge.
- R9: With space select other than 0 and the autovector bit set, a CPU-space cycle whose ADDR[3:1] equals the nonzero level keeps cs_n_o high. It raises avec_o for one clock at the point where term_ack_o would have been raised, and term_ack_o stays low.
- R10: A cyc_start_i that arrives while an access is in progress is ignored. The current access keeps its length and no second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 24 | Bus address, held for the whole cycle |
| cyc_space_i | input | 2 | Address space of the current cycle |
| cyc_start_i | input | 1 | One-clock marker of a new bus cycle |
| ext_ack_i | input | 1 | Acknowledge from the external device |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 1 | Register select: 0 base, 1 option |
| cfg_wdata_i | input | 32 | Register write data |
| cs_n_o | output | 1 | Active-low select strobe |
| term_ack_o | output | 1 | Internal termination acknowledge pulse |
| avec_o | output | 1 | Autovector request pulse |

## Verification
The termination path is driven through codes 0, 1, 5 and 13 and the fast code, which separates an off-by-one in the counter load from one in the strobe length. The external code is driven with the device acknowledge arriving late. Address patterns sit just inside the block top, just past it and just below the base, so a wrong mask width shows. Each space mode sees all four cycle space codes. Interrupt acknowledge cycles use matching and neighbouring levels, with the autovector bit both set and clear, which tells the strobe path, the autovector path and the ignored bit apart.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int TERM_W   = 4;
    localparam int LEVEL_W  = 3;
    localparam int OPT_W    = 2 + LEVEL_W + 1 + TERM_W;

    localparam logic [TERM_W-1:0] TERM_FAST = 4'hE;
    localparam logic [TERM_W-1:0] TERM_EXT  = 4'hF;

    // Space accepted by the channel (option field)
    typedef enum logic [1:0] {
        SEL_CPU   = 2'd0,
        SEL_USER  = 2'd1,
        SEL_SUPER = 2'd2,
        SEL_BOTH  = 2'd3
    } space_sel_e;

    // Space carried by the current bus cycle
    typedef enum logic [1:0] {
        CY_CPU   = 2'd0,
        CY_USER  = 2'd1,
        CY_SUPER = 2'd2,
        CY_RSVD  = 2'd3
    } cyc_space_e;

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_SEL  = 2'd1,
        HIT_AVEC = 2'd2
    } hit_e;

    typedef struct packed {
        space_sel_e          space;
        logic [LEVEL_W-1:0]  level;
        logic                avec;
        logic [TERM_W-1:0]   term;
    } opt_t;

    function automatic opt_t unpack_opt(input logic [OPT_W-1:0] raw);
        opt_t o;
        o.space = space_sel_e'(raw[9:8]);
        o.level = raw[7:5];
        o.avec  = raw[4];
        o.term  = raw[3:0];
        return o;
    endfunction

    // Counter value loaded at cycle start: clocks until the acknowledge clock
    function automatic logic [TERM_W-1:0] term_load(input logic [TERM_W-1:0] code);
        if (code == TERM_FAST || code == TERM_EXT)
            return '0;
        return code + 1'b1;
    endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
    import cs_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int BLK_MIN_LOG2 = 11,
    parameter int BS_W         = 3,
    parameter int CFG_W        = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we_i,
    input  logic                         sel_i,
    input  logic [CFG_W-1:0]             wdata_i,
    output logic [ADDR_W-1:BLK_MIN_LOG2] base_o,
    output logic [BS_W-1:0]              bsize_o,
    output opt_t                         opt_o
);

    logic [ADDR_W-1:BLK_MIN_LOG2] base_q;
    logic [BS_W-1:0]              bsize_q;
    logic [OPT_W-1:0]             opt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            bsize_q <= '0;
            opt_q   <= '0;
        end else if (we_i) begin
            if (sel_i) begin
                opt_q <= wdata_i[OPT_W-1:0];
            end else begin
                base_q  <= wdata_i[ADDR_W-1:BLK_MIN_LOG2];
                bsize_q <= wdata_i[BS_W-1:0];
            end
        end
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{wdata_i[CFG_W-1:ADDR_W], wdata_i[BLK_MIN_LOG2-1:BS_W]};

    assign base_o  = base_q;
    assign bsize_o = bsize_q;
    assign opt_o   = unpack_opt(opt_q);

endmodule

// File: rtl/cs_addr_match.sv
module cs_addr_match
    import cs_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int BLK_MIN_LOG2 = 11,
    parameter int BS_W         = 3
) (
    input  logic [ADDR_W-1:0]            addr_i,
    input  cyc_space_e                   cyc_space_i,
    input  logic [ADDR_W-1:BLK_MIN_LOG2] base_i,
    input  logic [BS_W-1:0]              bsize_i,
    input  opt_t                         opt_i,
    output hit_e                         hit_o
);

    localparam int CMP_N = ADDR_W - BLK_MIN_LOG2;
    localparam int OFF_W = $clog2(ADDR_W) + 1;

    logic [CMP_N-1:0] bit_miss;

    // A bit takes part in the compare only above the programmed block size
    for (genvar i = 0; i < CMP_N; i++) begin : g_cmp
        assign bit_miss[i] = (addr_i[BLK_MIN_LOG2 + i] != base_i[BLK_MIN_LOG2 + i])
                          && (OFF_W'(i) >= OFF_W'(bsize_i));
    end

    logic addr_ok;
    logic space_ok;
    logic level_hit;

    assign addr_ok   = ~|bit_miss;
    assign level_hit = (opt_i.level != '0) && (addr_i[LEVEL_W:1] == opt_i.level)
                    && (cyc_space_i == CY_CPU);

    always_comb begin
        unique case (opt_i.space)
            SEL_USER:  space_ok = (cyc_space_i == CY_USER);
            SEL_SUPER: space_ok = (cyc_space_i == CY_SUPER);
            SEL_BOTH:  space_ok = (cyc_space_i == CY_USER) || (cyc_space_i == CY_SUPER);
            default:   space_ok = 1'b0;
        endcase
    end

    always_comb begin
        hit_o = HIT_NONE;
        if (opt_i.space == SEL_CPU) begin
            if (level_hit)
                hit_o = HIT_SEL;
        end else if (space_ok && addr_ok) begin
            hit_o = HIT_SEL;
        end else if (opt_i.avec && level_hit) begin
            hit_o = HIT_AVEC;
        end
    end

endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer
    import cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  hit_e              hit_i,
    input  logic [TERM_W-1:0] term_i,
    input  logic              ext_ack_i,
    output logic              cs_n_o,
    output logic              term_ack_o,
    output logic              avec_o
);

    logic              active_q;
    logic              avec_kind_q;
    logic              ext_q;
    logic [TERM_W-1:0] cnt_q;

    logic expire;
    logic done;

    assign expire = active_q && !ext_q && (cnt_q == '0);
    assign done   = ext_q ? ext_ack_i : (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= 1'b0;
            avec_kind_q <= 1'b0;
            ext_q       <= 1'b0;
            cnt_q       <= '0;
        end else if (!active_q) begin
            if (start_i && hit_i != HIT_NONE) begin
                active_q    <= 1'b1;
                avec_kind_q <= (hit_i == HIT_AVEC);
                ext_q       <= (term_i == TERM_EXT);
                cnt_q       <= term_load(term_i);
            end
        end else if (done) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cs_n_o     = !(active_q && !avec_kind_q);
    assign term_ack_o = expire && !avec_kind_q;
    assign avec_o     = expire && avec_kind_q;

endmodule

// File: rtl/cs_channel.sv
module cs_channel
    import cs_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int BLK_MIN_LOG2 = 11,
    parameter int BS_W         = 3,
    parameter int CFG_W        = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        cyc_space_i,
    input  logic              cyc_start_i,
    input  logic              ext_ack_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic              cs_n_o,
    output logic              term_ack_o,
    output logic              avec_o
);

    logic [ADDR_W-1:BLK_MIN_LOG2] base;
    logic [BS_W-1:0]              bsize;
    opt_t                         opt;
    hit_e                         hit;

    cs_cfg_regs #(
        .ADDR_W(ADDR_W), .BLK_MIN_LOG2(BLK_MIN_LOG2), .BS_W(BS_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
        .base_o(base), .bsize_o(bsize), .opt_o(opt)
    );

    cs_addr_match #(
        .ADDR_W(ADDR_W), .BLK_MIN_LOG2(BLK_MIN_LOG2), .BS_W(BS_W)
    ) u_match (
        .addr_i(addr_i), .cyc_space_i(cyc_space_e'(cyc_space_i)),
        .base_i(base), .bsize_i(bsize), .opt_i(opt), .hit_o(hit)
    );

    cs_wait_timer u_timer (
        .clk(clk), .rst(rst),
        .start_i(cyc_start_i), .hit_i(hit), .term_i(opt.term),
        .ext_ack_i(ext_ack_i),
        .cs_n_o(cs_n_o), .term_ack_o(term_ack_o), .avec_o(avec_o)
    );

endmodule

// File: rtl/cs_channel_chk.sv
module cs_channel_chk (
    input logic clk,
    input logic rst,
    input logic ext_ack_i,
    input logic cs_n_o,
    input logic term_ack_o,
    input logic avec_o
);

    // R1: the outputs are idle in the clock after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cs_n_o && !term_ack_o && !avec_o));

    // R6: the acknowledge appears only while the strobe is low
    p_ack_in_sel_r6: assert property (@(posedge clk) disable iff (rst)
        term_ack_o |-> !cs_n_o);

    // R6: the acknowledge is the last clock of the access
    p_ack_ends_r6: assert property (@(posedge clk) disable iff (rst)
        term_ack_o |=> (cs_n_o && !term_ack_o));

    // R9: the autovector request never comes with the strobe or the acknowledge
    p_avec_alone_r9: assert property (@(posedge clk) disable iff (rst)
        avec_o |-> (cs_n_o && !term_ack_o));

    // R9: the autovector request lasts one clock
    p_avec_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        avec_o |=> !avec_o);

    // R8: without any acknowledge the strobe stays low
    p_hold_sel_r8: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !term_ack_o && !ext_ack_i) |=> !cs_n_o);

    // R6: at most one completion signal at a time
    p_one_done_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({term_ack_o, avec_o}));

endmodule

bind cs_channel cs_channel_chk u_chk (
    .clk(clk), .rst(rst), .ext_ack_i(ext_ack_i),
    .cs_n_o(cs_n_o), .term_ack_o(term_ack_o), .avec_o(avec_o)
);

// File: tb/cs_channel_tb.sv
module cs_channel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] addr;
    logic [1:0]  space;
    logic        start;
    logic        ext_ack;
    logic        we;
    logic        sel;
    logic [31:0] wdata;
    logic        cs_n;
    logic        ack;
    logic        avec;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cs_channel u_dut (
        .clk(clk), .rst(rst), .addr_i(addr), .cyc_space_i(space),
        .cyc_start_i(start), .ext_ack_i(ext_ack),
        .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wdata),
        .cs_n_o(cs_n), .term_ack_o(ack), .avec_o(avec)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] opt_word(input int sp, input int lvl, input int av, input int term);
        return 32'((sp << 8) | (lvl << 5) | (av << 4) | term);
    endfunction

    task automatic wr(input logic s, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    // One bus cycle: sample k counts negedges after the start edge
    task automatic run_cycle(input logic [23:0] a, input logic [1:0] sp,
                             input int ext_at, input int restart_at,
                             output int cs_cnt, output int ack_at, output int ack_cnt,
                             output int av_at, output int av_cnt);
        cs_cnt = 0; ack_at = -1; ack_cnt = 0; av_at = -1; av_cnt = 0;
        @(negedge clk);
        addr = a; space = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (k > 0) @(negedge clk);
            ext_ack = 1'b0;
            start = 1'b0;
            if (!cs_n) cs_cnt++;
            if (ack) begin ack_cnt++; if (ack_at < 0) ack_at = k; end
            if (avec) begin av_cnt++; if (av_at < 0) av_at = k; end
            if (k == ext_at) ext_ack = 1'b1;
            if (k == restart_at) start = 1'b1;
        end
        ext_ack = 1'b0;
        start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "cs_n after reset", int'(cs_n), 1);
        chk("R1", "ack after reset", int'(ack), 0);
        chk("R1", "avec after reset", int'(avec), 0);
    endtask

    task automatic t_zero_cfg;
        int c, aa, an, va, vn;
        for (int s = 0; s < 4; s++) begin
            run_cycle(24'h000000, 2'(s), -1, -1, c, aa, an, va, vn);
            chk("R1", $sformatf("zero config strobe clocks space %0d", s), c, 0);
        end
    endtask

    task automatic t_wait_sweep;
        int c, aa, an, va, vn;
        int codes[4] = '{0, 1, 5, 13};
        wr(1'b0, 32'h0012_0004);
        foreach (codes[i]) begin
            wr(1'b1, opt_word(1, 0, 0, codes[i]));
            run_cycle(24'h120100, 2'd1, -1, -1, c, aa, an, va, vn);
            chk("R6", $sformatf("strobe clocks code %0d", codes[i]), c, codes[i] + 2);
            chk("R6", $sformatf("ack position code %0d", codes[i]), aa, codes[i] + 1);
            chk("R6", $sformatf("ack count code %0d", codes[i]), an, 1);
        end
    endtask

    task automatic t_fast;
        int c, aa, an, va, vn;
        wr(1'b1, opt_word(1, 0, 0, 14));
        run_cycle(24'h120100, 2'd1, -1, -1, c, aa, an, va, vn);
        chk("R7", "fast strobe clocks", c, 1);
        chk("R7", "fast ack position", aa, 0);
        chk("R7", "fast ack count", an, 1);
    endtask

    task automatic t_external;
        int c, aa, an, va, vn;
        wr(1'b1, opt_word(1, 0, 0, 15));
        run_cycle(24'h120100, 2'd1, 4, -1, c, aa, an, va, vn);
        chk("R8", "external strobe clocks", c, 5);
        chk("R8", "external no internal ack", an, 0);
        run_cycle(24'h120100, 2'd1, 9, -1, c, aa, an, va, vn);
        chk("R8", "external late ack strobe clocks", c, 10);
    endtask

    task automatic t_addr;
        int c, aa, an, va, vn;
        wr(1'b1, opt_word(3, 0, 0, 0));
        run_cycle(24'h127FFE, 2'd1, -1, -1, c, aa, an, va, vn);
        chk("R3", "block top inside", c, 2);
        run_cycle(24'h128000, 2'd1, -1, -1, c, aa, an, va, vn);
        chk("R3", "just past block", c, 0);
        run_cycle(24'h11FFFE, 2'd2, -1, -1, c, aa, an, va, vn);
        chk("R3", "just below base", c, 0);
        wr(1'b0, 32'h0012_0000);
        run_cycle(24'h120800, 2'd1, -1, -1, c, aa, an, va, vn);
        chk("R2", "size code 0 excludes next 2KB", c, 0);
        run_cycle(24'h1207FE, 2'd1, -1, -1, c, aa, an, va, vn);
        chk("R2", "size code 0 covers first 2KB", c, 2);
    endtask

    task automatic t_space;
        int c, aa, an, va, vn;
        int exp_tab[3][4] = '{'{0, 1, 0, 0}, '{0, 0, 1, 0}, '{0, 1, 1, 0}};
        wr(1'b0, 32'h0012_0004);
        for (int m = 1; m < 4; m++) begin
            wr(1'b1, opt_word(m, 0, 0, 0));
            for (int s = 0; s < 4; s++) begin
                run_cycle(24'h120100, 2'(s), -1, -1, c, aa, an, va, vn);
                chk("R4", $sformatf("select %0d cycle space %0d", m, s), c, exp_tab[m-1][s] * 2);
            end
        end
    endtask

    task automatic t_iack;
        int c, aa, an, va, vn;
        wr(1'b1, opt_word(0, 5, 0, 1));
        run_cycle(24'hFFFFFA, 2'd0, -1, -1, c, aa, an, va, vn);
        chk("R5", "level match strobe clocks", c, 3);
        chk("R5", "level match ack position", aa, 2);
        run_cycle(24'hFFFFF8, 2'd0, -1, -1, c, aa, an, va, vn);
        chk("R5", "level mismatch", c, 0);
        run_cycle(24'hFFFFFA, 2'd1, -1, -1, c, aa, an, va, vn);
        chk("R5", "user cycle in CPU mode", c, 0);
        wr(1'b1, opt_word(0, 5, 1, 1));
        run_cycle(24'hFFFFFA, 2'd0, -1, -1, c, aa, an, va, vn);
        chk("R5", "avec bit ignored: strobe", c, 3);
        chk("R5", "avec bit ignored: ack count", an, 1);
        chk("R5", "avec bit ignored: no avec", vn, 0);
        wr(1'b1, opt_word(0, 0, 0, 1));
        run_cycle(24'hFFFFF0, 2'd0, -1, -1, c, aa, an, va, vn);
        chk("R5", "level zero never matches", c, 0);
    endtask

    task automatic t_avec;
        int c, aa, an, va, vn;
        wr(1'b1, opt_word(3, 3, 1, 2));
        run_cycle(24'hFFFFF6, 2'd0, -1, -1, c, aa, an, va, vn);
        chk("R9", "autovector no strobe", c, 0);
        chk("R9", "autovector position", va, 3);
        chk("R9", "autovector count", vn, 1);
        chk("R9", "autovector no ack", an, 0);
        run_cycle(24'hFFFFF4, 2'd0, -1, -1, c, aa, an, va, vn);
        chk("R9", "autovector level mismatch", vn, 0);
    endtask

    task automatic t_restart;
        int c, aa, an, va, vn;
        wr(1'b0, 32'h0012_0004);
        wr(1'b1, opt_word(1, 0, 0, 5));
        run_cycle(24'h120100, 2'd1, -1, 2, c, aa, an, va, vn);
        chk("R10", "restart strobe clocks", c, 7);
        chk("R10", "restart ack position", aa, 6);
        chk("R10", "restart ack count", an, 1);
    endtask

    initial begin
        rst = 1'b1; addr = '0; space = '0; start = 1'b0; ext_ack = 1'b0;
        we = 1'b0; sel = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_zero_cfg();
        t_wait_sweep();
        t_fast();
        t_external();
        t_addr();
        t_space();
        t_iack();
        t_avec();
        t_restart();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule